// File: doc/BRIEF.md
# Strap-Pin Configuration Controller

This block converts the global configuration straps of a multi-port 10/100 Ethernet transceiver into control-register bit values and per-port mode controls. The straps have two meanings. With auto-negotiation on, three of them become advertisement selects and a rising edge on strap 0 restarts negotiation on every port. With auto-negotiation off, the straps force the speed, the link-test setting and the fiber interface.

Every strap is asynchronous. Each one passes through a two-flop synchronizer before any logic uses it. A port runs in fiber mode when its own fiber-select pin is high or when fiber is forced globally. A port in fiber mode always bypasses its scrambler, and it is the only kind of port that the fiber-only full-duplex strap affects. The restart bit of each port is set by a restart event. It clears when that port's completion input fires.

Top module: `strap_cfg_ctrl`

## Requirements
- R1: With auto-negotiation off, `speed_100` follows synchronized `cfg0_pin` (1 = 100 Mbps, 0 = 10 Mbps). With auto-negotiation on, it is 0.
- R2: With auto-negotiation off, `link_test_dis` follows synchronized `cfg1_pin` (1 = link test disabled). With auto-negotiation on, it is 0.
- R3: With auto-negotiation off, `fx_sel_bit` follows synchronized `cfg2_pin` (1 = fiber for all ports, 0 = twisted pair). With auto-negotiation on, it is 0.
- R4: With auto-negotiation on, `adv_sel1`, `adv_sel2` and `adv_fd` follow synchronized `cfg1_pin`, `cfg2_pin` and `fd_all_pin`. With auto-negotiation off, all three are 0.
- R5: With auto-negotiation on, one low-to-high change on `cfg0_pin` makes `restart_pulse` high for exactly one clock. In that same cycle every bit of `restart_bit` becomes 1.
- R6: With auto-negotiation off, a rising `cfg0_pin` produces no `restart_pulse` and leaves `restart_bit` unchanged.
- R7: `restart_bit[i]` goes to 0 on the clock after `restart_done[i]` is seen high, unless a new restart happens in that same cycle. `restart_done` is a synchronous input. After reset, all restart bits are 0.
- R8: A `cfg0_pin` that is already high while reset is applied is taken as the starting level. It produces no restart pulse after reset is released.
- R9: Port i is in fiber mode when `port_fx_pin[i]` or `fx_sel_bit` is 1. A fiber port has `scr_bypass[i]` = 1 whatever `scr_byp_pin` is. A twisted-pair port has `scr_bypass[i]` equal to synchronized `scr_byp_pin`.
- R10: `duplex_full[i]` = `fd_all_pin` OR (`fd_fiber_pin` AND port i in fiber mode). All pins are synchronized.
- R11: A pin change that is set up before a clock edge appears at the outputs after the second clock edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| an_en_pin | input | 1 | Auto-negotiation enable strap |
| cfg0_pin | input | 1 | Strap 0: speed select, or restart edge |
| cfg1_pin | input | 1 | Strap 1: link-test disable, or advertisement select |
| cfg2_pin | input | 1 | Strap 2: fiber select, or advertisement select |
| fd_all_pin | input | 1 | Full-duplex enable for every port |
| fd_fiber_pin | input | 1 | Full-duplex enable for fiber ports only |
| scr_byp_pin | input | 1 | Scrambler bypass strap |
| port_fx_pin | input | NPORTS | Per-port fiber select |
| restart_done | input | NPORTS | Per-port negotiation-restart completion |
| speed_100 | output | 1 | Forced speed bit |
| restart_bit | output | NPORTS | Per-port self-clearing restart bit |
| restart_pulse | output | 1 | One-clock restart strobe |
| link_test_dis | output | 1 | 10 Mbps link-test disable bit |
| fx_sel_bit | output | 1 | Global fiber-select bit |
| scr_bypass | output | NPORTS | Per-port scrambler bypass |
| duplex_full | output | NPORTS | Per-port full-duplex control |
| adv_sel1 | output | 1 | Advertisement select from strap 1 |
| adv_sel2 | output | 1 | Advertisement select from strap 2 |
| adv_fd | output | 1 | Advertisement select from the all-port duplex strap |

## Verification
A wrong stage count in the synchronizer shows as output bits that change one edge too early or too late after a strap change. A bad edge detector shows either as a restart pulse right after reset or as a pulse that lasts two cycles. Both faults are visible within three clocks of the stimulus. A stuck restart bit shows in the first cycle after its completion input fires. A wrong fiber-mode decode shows at once on the scrambler-bypass and duplex outputs of the affected port.

// File: rtl/strap_cfg_pkg.sv
// Package: shared strap bundle for the configuration controller.
// Assumes every member is a single-bit level pin sampled asynchronously.
package strap_cfg_pkg;
    typedef struct packed {
        logic an_en;
        logic cfg0;
        logic cfg1;
        logic cfg2;
        logic fd_all;
        logic fd_fiber;
        logic scr_byp;
    } glob_pins_t;

    localparam int GLOB_W = $bits(glob_pins_t);
endpackage

// File: rtl/strap_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes STAGES >= 2. Every bit is synchronized on its own, and bits are
// not kept coherent with each other. The output resets to 0.
module strap_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [STAGES-1:0][W-1:0] stage_q;

    // Purpose: first stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_async;
    end

    // Purpose: each further stage copies the stage before it.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/strap_edge.sv
// Module: rising-edge detector that waits after reset before it arms.
// Assumes ARM_CYC is the synchronizer depth + 1. Until then the previous-value
// flop is still loading the first real level, so no edge is reported.
module strap_edge #(
    parameter int ARM_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    localparam int CW = $clog2(ARM_CYC + 1);

    logic [CW-1:0] arm_cnt;
    logic          armed;
    logic          lvl_prev;

    assign armed = (arm_cnt == CW'(ARM_CYC));

    // Purpose: count the edges after reset until the detector may arm.
    always_ff @(posedge clk) begin
        if (!rst_n)      arm_cnt <= '0;
        else if (!armed) arm_cnt <= arm_cnt + 1'b1;
    end

    // Purpose: keep the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= lvl;
    end

    assign rise = armed & lvl & ~lvl_prev;
endmodule

// File: rtl/strap_restart.sv
// Module: restart strobe and per-port self-clearing restart bits.
// Assumes trig is a single-cycle request. A new request wins over a
// completion that arrives in the same cycle.
module strap_restart #(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [NPORTS-1:0] done,
    output logic              pulse,
    output logic [NPORTS-1:0] bits
);
    // Purpose: register the one-clock restart strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= trig;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        // Purpose: set the port's restart bit on request, clear it on completion.
        always_ff @(posedge clk) begin
            if (!rst_n)       bits[p] <= 1'b0;
            else if (trig)    bits[p] <= 1'b1;
            else if (done[p]) bits[p] <= 1'b0;
        end
    end
endmodule

// File: rtl/strap_port_mode.sv
// Module: per-port scrambler and duplex decode.
// Assumes every input is already synchronized. Purely combinational.
module strap_port_mode #(
    parameter int NPORTS = 4
) (
    input  logic              fx_global,
    input  logic [NPORTS-1:0] port_fx,
    input  logic              scr_pin,
    input  logic              fd_all,
    input  logic              fd_fiber,
    output logic [NPORTS-1:0] scr_bypass,
    output logic [NPORTS-1:0] duplex_full
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic is_fiber;
        // Purpose: a port is fiber through its own select or the global force.
        assign is_fiber       = port_fx[p] | fx_global;
        // Purpose: fiber forces the bypass; twisted pair follows the strap.
        assign scr_bypass[p]  = is_fiber | scr_pin;
        // Purpose: the fiber-only duplex strap acts on fiber ports alone.
        assign duplex_full[p] = fd_all | (fd_fiber & is_fiber);
    end
endmodule

// File: rtl/strap_cfg_ctrl.sv
// Module: top of the strap-pin configuration controller.
// Assumes every strap is asynchronous and restart_done is synchronous to clk.
// The forced-mode bits and the advertisement selects are mutually exclusive,
// chosen by the synchronized auto-negotiation enable.
module strap_cfg_ctrl
    import strap_cfg_pkg::*;
#(
    parameter int NPORTS      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              an_en_pin,
    input  logic              cfg0_pin,
    input  logic              cfg1_pin,
    input  logic              cfg2_pin,
    input  logic              fd_all_pin,
    input  logic              fd_fiber_pin,
    input  logic              scr_byp_pin,
    input  logic [NPORTS-1:0] port_fx_pin,
    input  logic [NPORTS-1:0] restart_done,
    output logic              speed_100,
    output logic [NPORTS-1:0] restart_bit,
    output logic              restart_pulse,
    output logic              link_test_dis,
    output logic              fx_sel_bit,
    output logic [NPORTS-1:0] scr_bypass,
    output logic [NPORTS-1:0] duplex_full,
    output logic              adv_sel1,
    output logic              adv_sel2,
    output logic              adv_fd
);
    localparam int SYNC_W  = GLOB_W + NPORTS;
    localparam int ARM_CYC = SYNC_STAGES + 1;

    glob_pins_t        pins_raw;
    glob_pins_t        pins_s;
    logic [SYNC_W-1:0] sync_in;
    logic [SYNC_W-1:0] sync_out;
    logic [NPORTS-1:0] port_fx_s;
    logic              an_s;
    logic              fd_all_s;
    logic              cfg0_rise;
    logic              restart_trig;

    // Purpose: bundle the global straps and the per-port selects for synchronizing.
    always_comb begin
        pins_raw.an_en    = an_en_pin;
        pins_raw.cfg0     = cfg0_pin;
        pins_raw.cfg1     = cfg1_pin;
        pins_raw.cfg2     = cfg2_pin;
        pins_raw.fd_all   = fd_all_pin;
        pins_raw.fd_fiber = fd_fiber_pin;
        pins_raw.scr_byp  = scr_byp_pin;
        sync_in           = {pins_raw, port_fx_pin};
    end

    strap_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(sync_in),
        .q_sync (sync_out)
    );

    assign pins_s    = sync_out[SYNC_W-1 -: GLOB_W];
    assign port_fx_s = sync_out[NPORTS-1:0];
    assign an_s      = pins_s.an_en;
    assign fd_all_s  = pins_s.fd_all;

    strap_edge #(.ARM_CYC(ARM_CYC)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (pins_s.cfg0),
        .rise (cfg0_rise)
    );

    // Purpose: a strap-0 edge restarts negotiation only while it is enabled.
    assign restart_trig = cfg0_rise & an_s;

    strap_restart #(.NPORTS(NPORTS)) u_restart (
        .clk  (clk),
        .rst_n(rst_n),
        .trig (restart_trig),
        .done (restart_done),
        .pulse(restart_pulse),
        .bits (restart_bit)
    );

    // Purpose: the forced-mode bits apply only with negotiation off.
    always_comb begin
        speed_100     = ~an_s & pins_s.cfg0;
        link_test_dis = ~an_s & pins_s.cfg1;
        fx_sel_bit    = ~an_s & pins_s.cfg2;
    end

    // Purpose: the advertisement selects apply only with negotiation on.
    always_comb begin
        adv_sel1 = an_s & pins_s.cfg1;
        adv_sel2 = an_s & pins_s.cfg2;
        adv_fd   = an_s & pins_s.fd_all;
    end

    strap_port_mode #(.NPORTS(NPORTS)) u_port_mode (
        .fx_global  (fx_sel_bit),
        .port_fx    (port_fx_s),
        .scr_pin    (pins_s.scr_byp),
        .fd_all     (pins_s.fd_all),
        .fd_fiber   (pins_s.fd_fiber),
        .scr_bypass (scr_bypass),
        .duplex_full(duplex_full)
    );
endmodule

// File: rtl/strap_cfg_ctrl_chk.sv
// Module: assertion checker, bound to strap_cfg_ctrl.
// Assumes an_s and fd_all_s are the top's synchronized strap levels.
module strap_cfg_ctrl_chk #(
    parameter int NPORTS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              an_s,
    input logic              fd_all_s,
    input logic              speed_100,
    input logic              link_test_dis,
    input logic              fx_sel_bit,
    input logic              adv_sel1,
    input logic              adv_sel2,
    input logic              adv_fd,
    input logic              restart_pulse,
    input logic [NPORTS-1:0] restart_bit,
    input logic [NPORTS-1:0] restart_done,
    input logic [NPORTS-1:0] scr_bypass,
    input logic [NPORTS-1:0] duplex_full
);
    // R1, R2, R3: with negotiation on, no forced-mode bit is set
    p_an_masks_forced_r1: assert property (@(posedge clk) disable iff (!rst_n)
        an_s |-> !(speed_100 || link_test_dis || fx_sel_bit));

    p_adv_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !an_s |-> !(adv_sel1 || adv_sel2 || adv_fd));

    p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |=> !restart_pulse);

    p_pulse_sets_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |-> (&restart_bit));

    // R6: no restart strobe while negotiation is off
    p_no_pulse_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!an_s && !$past(an_s)) |=> !restart_pulse);

    p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (restart_pulse || ((restart_bit & $past(restart_done)) == '0)));

    p_fiber_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fx_sel_bit |-> (&scr_bypass));

    p_fd_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fd_all_s |-> (&duplex_full));
endmodule

bind strap_cfg_ctrl strap_cfg_ctrl_chk #(.NPORTS(NPORTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .an_s         (an_s),
    .fd_all_s     (fd_all_s),
    .speed_100    (speed_100),
    .link_test_dis(link_test_dis),
    .fx_sel_bit   (fx_sel_bit),
    .adv_sel1     (adv_sel1),
    .adv_sel2     (adv_sel2),
    .adv_fd       (adv_fd),
    .restart_pulse(restart_pulse),
    .restart_bit  (restart_bit),
    .restart_done (restart_done),
    .scr_bypass   (scr_bypass),
    .duplex_full  (duplex_full)
);

// File: tb/test_strap_cfg_ctrl.sv
`timescale 1ns/1ps
module test_strap_cfg_ctrl;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         an_en_pin = 1'b0, cfg0_pin = 1'b0, cfg1_pin = 1'b0, cfg2_pin = 1'b0;
    logic         fd_all_pin = 1'b0, fd_fiber_pin = 1'b0, scr_byp_pin = 1'b0;
    logic [N-1:0] port_fx_pin = '0, restart_done = '0;
    logic         speed_100, restart_pulse, link_test_dis, fx_sel_bit;
    logic         adv_sel1, adv_sel2, adv_fd;
    logic [N-1:0] restart_bit, scr_bypass, duplex_full;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    strap_cfg_ctrl #(.NPORTS(N), .SYNC_STAGES(2)) i_strap_cfg_ctrl (
        .clk(clk), .rst_n(rst_n), .an_en_pin(an_en_pin), .cfg0_pin(cfg0_pin),
        .cfg1_pin(cfg1_pin), .cfg2_pin(cfg2_pin), .fd_all_pin(fd_all_pin),
        .fd_fiber_pin(fd_fiber_pin), .scr_byp_pin(scr_byp_pin),
        .port_fx_pin(port_fx_pin), .restart_done(restart_done),
        .speed_100(speed_100), .restart_bit(restart_bit), .restart_pulse(restart_pulse),
        .link_test_dis(link_test_dis), .fx_sel_bit(fx_sel_bit), .scr_bypass(scr_bypass),
        .duplex_full(duplex_full), .adv_sel1(adv_sel1), .adv_sel2(adv_sel2), .adv_fd(adv_fd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected-value model from the requirements
    function automatic logic [N-1:0] exp_fiber();
        return port_fx_pin | {N{~an_en_pin & cfg2_pin}};
    endfunction
    function automatic logic [N-1:0] exp_scr();
        return exp_fiber() | {N{scr_byp_pin}};
    endfunction
    function automatic logic [N-1:0] exp_dup();
        return {N{fd_all_pin}} | ({N{fd_fiber_pin}} & exp_fiber());
    endfunction

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic check_static();
        check("R1 speed",     32'(speed_100),     32'(~an_en_pin & cfg0_pin));
        check("R2 link test", 32'(link_test_dis), 32'(~an_en_pin & cfg1_pin));
        check("R3 fx select", 32'(fx_sel_bit),    32'(~an_en_pin & cfg2_pin));
        check("R4 adv",       32'({adv_sel1, adv_sel2, adv_fd}),
              32'({an_en_pin & cfg1_pin, an_en_pin & cfg2_pin, an_en_pin & fd_all_pin}));
        check("R9 scrambler", 32'(scr_bypass),    32'(exp_scr()));
        check("R10 duplex",   32'(duplex_full),   32'(exp_dup()));
    endtask

    // Raise cfg0 and count the sampled pulse cycles
    task automatic rise_and_count(output int pulses);
        pulses = 0;
        cfg0_pin = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (restart_pulse) pulses++;
        end
    endtask

    initial begin : watchdog
        #(8 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int pulses;
        void'($urandom(32'd2024));
        // R8: cfg0 high through reset with negotiation on
        an_en_pin = 1'b1;
        cfg0_pin  = 1'b1;
        wait_neg(4);
        check("R7 reset bits", 32'(restart_bit), 32'(0));
        check("R5 reset pulse", 32'(restart_pulse), 32'(0));
        rst_n = 1'b1;
        pulses = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (restart_pulse) pulses++;
        end
        check("R8 no pulse after reset", 32'(pulses), 32'(0));
        check("R8 bits after reset", 32'(restart_bit), 32'(0));

        // R5: rising edge with negotiation on
        cfg0_pin = 1'b0;
        wait_neg(4);
        rise_and_count(pulses);
        check("R5 pulse count", 32'(pulses), 32'(1));
        check("R5 bits set", 32'(restart_bit), 32'({N{1'b1}}));

        // R7: clear one port, then all
        restart_done = 4'b0010;
        @(negedge clk);
        restart_done = '0;
        check("R7 one port cleared", 32'(restart_bit), 32'(4'b1101));
        restart_done = 4'b1101;
        @(negedge clk);
        restart_done = '0;
        check("R7 all cleared", 32'(restart_bit), 32'(0));

        // R6: rising edge with negotiation off
        an_en_pin = 1'b0;
        cfg0_pin  = 1'b0;
        wait_neg(5);
        rise_and_count(pulses);
        check("R6 no pulse", 32'(pulses), 32'(0));
        check("R6 bits unchanged", 32'(restart_bit), 32'(0));
        check("R1 forced 100", 32'(speed_100), 32'(1));

        // R11: two-edge latency on strap 1
        cfg1_pin = 1'b0;
        wait_neg(4);
        cfg1_pin = 1'b1;
        @(negedge clk);
        check("R11 after one edge", 32'(link_test_dis), 32'(0));
        @(negedge clk);
        check("R11 after two edges", 32'(link_test_dis), 32'(1));

        // R9 and R10 directed: fiber forced globally, bypass pin low
        an_en_pin = 1'b0; cfg2_pin = 1'b1; scr_byp_pin = 1'b0;
        fd_all_pin = 1'b0; fd_fiber_pin = 1'b1; port_fx_pin = '0;
        wait_neg(4);
        check("R9 global fiber bypass", 32'(scr_bypass), 32'({N{1'b1}}));
        check("R10 fiber duplex", 32'(duplex_full), 32'({N{1'b1}}));
        // twisted pair: the fiber-only duplex strap is ignored on TP ports
        cfg2_pin = 1'b0; port_fx_pin = 4'b0100;
        wait_neg(4);
        check("R9 mixed bypass", 32'(scr_bypass), 32'(4'b0100));
        check("R10 mixed duplex", 32'(duplex_full), 32'(4'b0100));

        // Random stimulus against the bench model
        for (int it = 0; it < 200; it++) begin
            logic [31:0] r;
            r = $urandom;
            an_en_pin    = r[0];
            cfg0_pin     = r[1];
            cfg1_pin     = r[2];
            cfg2_pin     = r[3];
            fd_all_pin   = r[4];
            fd_fiber_pin = r[5];
            scr_byp_pin  = r[6];
            port_fx_pin  = r[10:7];
            wait_neg(3);
            check_static();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule